// File: doc/BRIEF.md
# Bus Master Retry and Disconnect Sequencer

This block sits on the initiator side of a bridge and decides what happens after each attempt of a transaction on a parallel bus. A descriptor (kind, start byte address, length in dwords) is loaded while the block is idle. The block then launches an attempt and waits for the termination code of that attempt. A normal ending or an abort closes the transaction with a final status. A disconnect launches the rest of the transfer at once. A retry launches the same transfer again after a minimum idle gap.

A retry is treated as flow control and never as a fault. There is no limit on the number of retries, so a posted write is repeated until it ends normally or with an abort. While a delayed read or delayed write is backing off after a retry, the block raises a flag. The surrounding queue logic uses this flag to let other memory reads, split completions and writes go first. Arbitration and the bus signalling itself are handled elsewhere.

Top module: `retry_disc_sequencer`

## Requirements
- R1: When idle, `startValid` with a nonzero `startLen` is accepted at that clock edge. `busy` is high from the next cycle. `issueValid` is high for exactly that next cycle, with `issueAddr`/`issueLen` equal to the loaded address and length.
- R2: Termination code 0 (normal), seen while an attempt is outstanding, gives a one-cycle `doneValid` with `doneStatus` 0 in the cycle after that edge, and `busy` drops in the same cycle.
- R3: Termination code 1 (disconnect) with a count c smaller than the remaining length gives `issueValid` in the cycle after that edge. The new address is the previous one plus 4*c and the new length is the remainder minus c. A count of 0 re-launches unchanged.
- R4: A disconnect whose count is equal to or greater than the remaining length completes like a normal ending, with status 0.
- R5: Termination code 2 (retry) gives exactly GAP cycles (default 2) with no `issueValid`, starting right after the edge that sampled it. The same address and length are launched in the following cycle. Retries are repeated with no limit.
- R6: A retry produces neither `doneValid` nor `errPulse`. `errPulse` is high only together with a `doneValid` whose status is nonzero.
- R7: Code 3 (target abort) finishes with `doneStatus` 1 and code 4 (master abort) with `doneStatus` 2. In both cases `errPulse` is high with `doneValid` and no further attempt is launched.
- R8: `passOk` is high exactly during the back-off cycles of a transaction whose `startKind` bit 1 is set (2 = delayed read, 3 = delayed write). It stays low for kinds 0 (posted write) and 1 (memory read).
- R9: The following are ignored: `startValid` while busy, a zero-length start, `termValid` outside an outstanding attempt (including the launch cycle), and codes 5 to 7.
- R10: A start presented in the same cycle as `doneValid` is accepted, and its launch follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Load a new descriptor |
| startKind | input | 2 | 0 posted write, 1 memory read, 2 delayed read, 3 delayed write |
| startAddr | input | ADDR_W | Start byte address |
| startLen | input | LEN_W | Length in dwords |
| termValid | input | 1 | Termination of the outstanding attempt |
| termCode | input | 3 | 0 normal, 1 disconnect, 2 retry, 3 target abort, 4 master abort |
| termCount | input | LEN_W | Dwords moved before a disconnect |
| issueValid | output | 1 | Launch an attempt this cycle |
| issueAddr | output | ADDR_W | Address of the attempt |
| issueLen | output | LEN_W | Dword length of the attempt |
| busy | output | 1 | A transaction is in progress |
| doneValid | output | 1 | Transaction finished (one cycle) |
| doneStatus | output | 2 | 0 ok, 1 target abort, 2 master abort |
| errPulse | output | 1 | Error report, aborts only |
| passOk | output | 1 | Other traffic may overtake the delayed transaction |

## Verification
Two functions can land in the same cycle: the completion pulse of one transaction and the acceptance of the next descriptor. The bench provokes this by presenting a new start exactly in the cycle where `doneValid` is high, after a normal ending and after a disconnect whose count overshoots the remainder. A behavioural model predicts every output on every clock. The overlap is judged correct only if the completion status is right and the new launch appears one cycle later with the new address. A second overlap comes from driving a start and a termination during the launch cycle, where both must leave no trace.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    TERM_NORMAL = 3'd0,
    TERM_DISC   = 3'd1,
    TERM_RETRY  = 3'd2,
    TERM_TABORT = 3'd3,
    TERM_MABORT = 3'd4
  } termCode_e;

  typedef enum logic [1:0] {
    STAT_OK     = 2'd0,
    STAT_TABORT = 2'd1,
    STAT_MABORT = 2'd2
  } doneStat_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      advance;
    logic      finish;
    doneStat_e status;
  } seqStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        startKind,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [LEN_W-1:0]  termCount,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  remLen,
  output logic              isDelayed,
  output logic              lastChunk,
  output logic              doneValid,
  output doneStat_e         doneStatus,
  output logic              errPulse
);

  localparam int STEP_W = LEN_W + 2;

  logic [1:0]        kindReg;
  logic [STEP_W-1:0] byteStep;

  assign byteStep  = {termCount, 2'b00};
  assign lastChunk = (termCount >= remLen);
  assign isDelayed = kindReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remLen  <= '0;
      kindReg <= '0;
    end else if (strobe.load) begin
      curAddr <= startAddr;
      remLen  <= startLen;
      kindReg <= startKind;
    end else if (strobe.advance) begin
      curAddr <= curAddr + ADDR_W'(byteStep);
      remLen  <= remLen - termCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      doneStatus <= STAT_OK;
      errPulse   <= 1'b0;
    end else begin
      doneValid  <= strobe.finish;
      doneStatus <= strobe.finish ? strobe.status : STAT_OK;
      errPulse   <= strobe.finish && (strobe.status != STAT_OK);
    end
  end

  // R3
  adv_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (remLen != '0));

  // R6
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (doneValid && doneStatus != STAT_OK));

  // R1
  load_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (remLen != '0));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       startLenNz,
  input  logic       termValid,
  input  logic [2:0] termCode,
  input  logic       lastChunk,
  input  logic       isDelayed,
  output seqStrobe_t strobe,
  output logic       issueValid,
  output logic       busy,
  output logic       passOk
);

  localparam int GAP_W = $clog2(GAP + 1);

  typedef enum logic [1:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_BACKOFF
  } seqState_e;

  seqState_e        state, nextState;
  logic [GAP_W-1:0] gapCnt;
  logic             gapDone;

  assign gapDone    = (gapCnt == GAP_W'(GAP - 1));
  assign issueValid = (state == S_ISSUE);
  assign busy       = (state != S_IDLE);
  assign passOk     = (state == S_BACKOFF) && isDelayed;

  always_comb begin
    nextState = state;
    strobe    = '{load: 1'b0, advance: 1'b0, finish: 1'b0, status: STAT_OK};
    unique case (state)
      S_IDLE: begin
        if (startValid && startLenNz) begin
          strobe.load = 1'b1;
          nextState   = S_ISSUE;
        end
      end
      S_ISSUE: nextState = S_WAIT;
      S_WAIT: begin
        if (termValid) begin
          case (termCode)
            TERM_NORMAL: begin
              strobe.finish = 1'b1;
              nextState     = S_IDLE;
            end
            TERM_DISC: begin
              if (lastChunk) begin
                strobe.finish = 1'b1;
                nextState     = S_IDLE;
              end else begin
                strobe.advance = 1'b1;
                nextState      = S_ISSUE;
              end
            end
            TERM_RETRY: nextState = S_BACKOFF;
            TERM_TABORT: begin
              strobe.finish = 1'b1;
              strobe.status = STAT_TABORT;
              nextState     = S_IDLE;
            end
            TERM_MABORT: begin
              strobe.finish = 1'b1;
              strobe.status = STAT_MABORT;
              nextState     = S_IDLE;
            end
            default: nextState = S_WAIT;
          endcase
        end
      end
      S_BACKOFF: if (gapDone) nextState = S_ISSUE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (state == S_BACKOFF && !gapDone) gapCnt <= gapCnt + 1'b1;
      else                                gapCnt <= '0;
    end
  end

  // checker-only tracking of cycles since the last retry
  logic             retryArmed;
  logic [GAP_W-1:0] sinceRetry;
  logic             retrySeen;

  assign retrySeen = (state == S_WAIT) && termValid && (termCode == TERM_RETRY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryArmed <= 1'b0;
      sinceRetry <= '0;
    end else if (retrySeen) begin
      retryArmed <= 1'b1;
      sinceRetry <= '0;
    end else begin
      if (issueValid) retryArmed <= 1'b0;
      if (sinceRetry != GAP_W'(GAP)) sinceRetry <= sinceRetry + 1'b1;
    end
  end

  // R5
  retry_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && retryArmed) |-> (sinceRetry == GAP_W'(GAP)));

  // R8
  pass_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    passOk |-> (isDelayed && busy && !issueValid));

  // R1
  issue_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (issueValid && busy));

  // R7
  abort_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_WAIT) && termValid &&
     (termCode == TERM_TABORT || termCode == TERM_MABORT)) |=> !busy);

  // R6
  retry_no_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    retrySeen |-> !strobe.finish);

endmodule

// File: rtl/retry_disc_sequencer.sv
module retry_disc_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startKind,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  startLen,
  input  logic              termValid,
  input  logic [2:0]        termCode,
  input  logic [LEN_W-1:0]  termCount,
  output logic              issueValid,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [LEN_W-1:0]  issueLen,
  output logic              busy,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic              errPulse,
  output logic              passOk
);

  seqStrobe_t strobe;
  logic       lastChunk;
  logic       isDelayed;
  doneStat_e  statusInt;

  seq_control #(.GAP(GAP)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startLenNz (startLen != '0),
    .termValid  (termValid),
    .termCode   (termCode),
    .lastChunk  (lastChunk),
    .isDelayed  (isDelayed),
    .strobe     (strobe),
    .issueValid (issueValid),
    .busy       (busy),
    .passOk     (passOk)
  );

  seq_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startKind  (startKind),
    .startAddr  (startAddr),
    .startLen   (startLen),
    .termCount  (termCount),
    .curAddr    (issueAddr),
    .remLen     (issueLen),
    .isDelayed  (isDelayed),
    .lastChunk  (lastChunk),
    .doneValid  (doneValid),
    .doneStatus (statusInt),
    .errPulse   (errPulse)
  );

  assign doneStatus = statusInt;

endmodule

// File: tb/retry_disc_sequencer_tb.sv
module retry_disc_sequencer_tb;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 10;
  localparam int GAP    = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startValid = 1'b0;
  logic [1:0]        startKind = '0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [LEN_W-1:0]  startLen = '0;
  logic              termValid = 1'b0;
  logic [2:0]        termCode = '0;
  logic [LEN_W-1:0]  termCount = '0;
  logic              issueValid, busy, doneValid, errPulse, passOk;
  logic [ADDR_W-1:0] issueAddr;
  logic [LEN_W-1:0]  issueLen;
  logic [1:0]        doneStatus;

  retry_disc_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .GAP(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startKind(startKind),
    .startAddr(startAddr), .startLen(startLen), .termValid(termValid),
    .termCode(termCode), .termCount(termCount), .issueValid(issueValid),
    .issueAddr(issueAddr), .issueLen(issueLen), .busy(busy),
    .doneValid(doneValid), .doneStatus(doneStatus), .errPulse(errPulse),
    .passOk(passOk)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string curTag = "R1 reset";

  // behavioural reference model
  int              mState = 0;  // 0 idle, 1 launch, 2 outstanding, 3 back-off
  int              mGap = 0;
  int              mRem = 0;
  logic [ADDR_W-1:0] mAddr = '0;
  logic [1:0]      mKind = '0;
  bit              mDone = 1'b0;
  bit              mErr = 1'b0;
  int              mStat = 0;

  task automatic modelFinish(int st);
    mDone  = 1'b1;
    mStat  = st;
    mErr   = (st != 0);
    mState = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mGap = 0; mDone = 0; mErr = 0; mStat = 0;
    end else begin
      mDone = 0; mErr = 0; mStat = 0;
      case (mState)
        0: if (startValid && startLen != 0) begin
             mAddr = startAddr; mRem = int'(startLen); mKind = startKind; mState = 1;
           end
        1: mState = 2;
        2: if (termValid) begin
             case (termCode)
               3'd0: modelFinish(0);
               3'd1: if (int'(termCount) >= mRem) modelFinish(0);
                     else begin
                       mAddr = mAddr + 4 * termCount;
                       mRem  = mRem - int'(termCount);
                       mState = 1;
                     end
               3'd2: begin mState = 3; mGap = 0; end
               3'd3: modelFinish(1);
               3'd4: modelFinish(2);
               default: ;
             endcase
           end
        3: if (mGap == GAP - 1) mState = 1; else mGap++;
        default: mState = 0;
      endcase
    end
  end

  task automatic cmp(string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", curTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp("busy", busy, mState != 0);
      cmp("issueValid", issueValid, mState == 1);
      cmp("passOk", passOk, (mState == 3) && mKind[1]);
      cmp("doneValid", doneValid, mDone);
      cmp("doneStatus", doneStatus, mStat);
      cmp("errPulse", errPulse, mErr);
      if (mState == 1) begin
        cmp("issueAddr", issueAddr, mAddr);
        cmp("issueLen", issueLen, mRem);
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  task automatic startTxn(logic [1:0] k, logic [ADDR_W-1:0] a, int len);
    startValid = 1'b1; startKind = k; startAddr = a; startLen = LEN_W'(len);
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic term(int code, int count);
    termValid = 1'b1; termCode = 3'(code); termCount = LEN_W'(count);
    @(negedge clk);
    termValid = 1'b0;
  endtask

  task automatic respond(int code, int count, int delay);
    while (!issueValid) @(negedge clk);
    repeat (delay) @(negedge clk);
    term(code, count);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    curTag = "R1 R2 normal read";
    startTxn(2'd1, 32'h0000_1000, 4);
    respond(0, 0, 2);
    waitIdle();

    curTag = "R3 R4 disconnect chain";
    startTxn(2'd1, 32'h0000_2000, 8);
    respond(1, 3, 1);
    respond(1, 0, 1);
    respond(1, 9, 1);
    waitIdle();

    curTag = "R5 R6 posted write retried";
    startTxn(2'd0, 32'h0000_3000, 2);
    respond(2, 0, 1);
    respond(2, 0, 1);
    respond(2, 0, 3);
    respond(0, 0, 1);
    waitIdle();

    curTag = "R8 delayed read back-off";
    startTxn(2'd2, 32'h0000_4000, 5);
    respond(2, 0, 1);
    respond(0, 0, 1);
    waitIdle();

    curTag = "R8 delayed write retry then disconnect";
    startTxn(2'd3, 32'h0000_4800, 6);
    respond(2, 0, 1);
    respond(1, 4, 1);
    respond(2, 0, 2);
    respond(0, 0, 1);
    waitIdle();

    curTag = "R8 memory read no pass";
    startTxn(2'd1, 32'h0000_4C00, 3);
    respond(2, 0, 1);
    respond(0, 0, 1);
    waitIdle();

    curTag = "R7 target abort after disconnect";
    startTxn(2'd1, 32'h0000_5000, 6);
    respond(1, 2, 1);
    respond(3, 0, 2);
    waitIdle();

    curTag = "R7 master abort after retry";
    startTxn(2'd3, 32'h0000_5800, 4);
    respond(2, 0, 1);
    respond(4, 0, 1);
    waitIdle();

    curTag = "R9 ignored inputs";
    startTxn(2'd1, 32'h0000_6000, 4);
    startValid = 1'b1; startAddr = 32'h0000_6F00; startLen = 10'd7;
    termValid = 1'b1; termCode = 3'd0;
    @(negedge clk);
    termValid = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    term(5, 0);
    term(7, 0);
    @(negedge clk);
    term(0, 0);
    waitIdle();
    startTxn(2'd1, 32'h0000_7000, 0);
    term(0, 0);
    repeat (3) @(negedge clk);

    curTag = "R10 start in done cycle";
    startTxn(2'd1, 32'h0000_8000, 2);
    respond(0, 0, 1);
    startTxn(2'd2, 32'h0000_9000, 3);
    respond(1, 5, 1);
    startTxn(2'd0, 32'h0000_A000, 1);
    respond(0, 0, 1);
    waitIdle();

    repeat (2) @(negedge clk);
    summary();
  end

endmodule